// File: doc/BRIEF.md
# Overcharge Delay Timer With Glitch Filter

This block turns per-cell overvoltage flags into one charge-control output for a pack of series cells. A cell comparator outside the block raises `cell_over` while its cell sits above the detection level. It raises `cell_hold` while the cell sits above the release level, which is the detection level lowered by the hysteresis. The block counts 1 ms timebase ticks on which any cell is over the detection level. When that accumulated time reaches the selected delay, the block enters overcharge status and drives `chg_block_o` high. A dip in which no cell is over the level only pauses the count. The count is thrown away only when the dip lasts the timer-reset time or longer. Overcharge status ends on the first tick on which no cell is above the release level.

An upstream block in a cascade passes its own charge-control decision in on `ctl_in`. The output follows it high within one tick, whatever the local status. A self-test controller can assert `quick_in` to cut the detection delay to a few milliseconds while it checks the detection path.

The controller is a four-state machine. **ST_IDLE** is normal status with no count. **ST_COUNT** means a count is running and some cell is over. **ST_GAP** means a count is paused in a dip. **ST_TRIP** is overcharge status. The transitions are named as follows. *start* goes from ST_IDLE to ST_COUNT. *resume* goes from ST_GAP to ST_COUNT. *dip* goes from ST_COUNT to ST_GAP. *filter-expire* goes from ST_GAP to ST_IDLE. *trip* goes from ST_IDLE, ST_COUNT or ST_GAP to ST_TRIP. *release* goes from ST_TRIP to ST_IDLE. Every state and counter update happens only on a cycle with `tick` high.

Top module: `ovc_delay_guard`

## Requirements
- R1: After synchronous active-low reset the output is low, the block is in ST_IDLE and both counters are zero.
- R2: Each tick on which any `cell_over` bit is high adds one to the accumulated count. The output rises at the edge of the tick that brings the count to the target T. The first over tick counts as one. T is chosen by `dly_sel`: 0 gives DLY_512, 1 gives DLY_1S, 2 gives DLY_2S, 3 gives DLY_4S, and 4 to 7 give DLY_8S. The defaults are 512, 1000, 2000, 4000 and 8000 ticks.
- R3: A run of fewer than TRST_MS consecutive ticks with no `cell_over` bit high keeps the accumulated count. The count neither grows nor is lost during such a run.
- R4: A run of TRST_MS consecutive ticks with no `cell_over` bit high clears the count. The next over tick starts again from one.
- R5: In overcharge status the output stays high while any `cell_hold` bit is high. On the first tick with all `cell_hold` bits low, the block returns to ST_IDLE, and the output goes low unless `ctl_in` is high.
- R6: `ctl_in` high on a tick makes the output high after that tick, in any status.
- R7: While `quick_in` is high, the target T is DLY_QUICK (default 8) regardless of `dly_sel`.
- R8: `dly_sel` is captured only while the block is in ST_IDLE. A change during a count or during overcharge status has no effect on that count.
- R9: On cycles with `tick` low, the output and all state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle 1 ms timebase strobe |
| cell_over | input | NCELL | Cell above detection level, one bit per cell |
| cell_hold | input | NCELL | Cell above release level, one bit per cell |
| ctl_in | input | 1 | Upstream charge-control request, forces the output high |
| quick_in | input | 1 | Self-test shortened-delay request |
| dly_sel | input | 3 | Detection delay select code |
| chg_block_o | output | 1 | Charge-control output, high to stop charging |

## Verification
The upstream force and the overcharge release can fall on the same tick. In that case `ctl_in` is high on the very tick where every `cell_hold` bit drops, and the output must stay high even though the state returns to ST_IDLE. A directed sequence provokes this collision in overcharge status. The long random run produces it again, because it draws `ctl_in` and the hold flags independently. A bench model that applies the release and the force separately and ORs them judges every tick. The same model also judges the near-collision in which a dip ends exactly one tick before the filter would expire.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_GAP   = 2'd2,
        ST_TRIP  = 2'd3
    } ovc_state_e;

    localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/ovc_count.sv
module ovc_count #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/ovc_delay_sel.sv
module ovc_delay_sel
    import ovc_pkg::*;
#(
    parameter int unsigned DLY_512   = 512,
    parameter int unsigned DLY_1S    = 1000,
    parameter int unsigned DLY_2S    = 2000,
    parameter int unsigned DLY_4S    = 4000,
    parameter int unsigned DLY_8S    = 8000,
    parameter int unsigned DLY_QUICK = 8,
    parameter int unsigned DW        = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEL_W-1:0] sel,
    input  logic             quick,
    output logic [SEL_W-1:0] sel_q,
    output logic [DW-1:0]    tgt
);
    localparam int unsigned NOPT = 5;
    localparam int unsigned OPTS [NOPT] = '{DLY_512, DLY_1S, DLY_2S, DLY_4S, DLY_8S};

    logic [DW-1:0] opt_val [NOPT];

    for (genvar g = 0; g < NOPT; g++) begin : g_opt
        assign opt_val[g] = DW'(OPTS[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (capture) begin
            sel_q <= sel;
        end
    end

    always_comb begin
        if (quick) begin
            tgt = DW'(DLY_QUICK);
        end else if (sel_q >= SEL_W'(NOPT - 1)) begin
            tgt = opt_val[NOPT-1];
        end else begin
            tgt = opt_val[sel_q];
        end
    end
endmodule

// File: rtl/ovc_delay_guard.sv
module ovc_delay_guard
    import ovc_pkg::*;
#(
    parameter int unsigned NCELL     = 5,
    parameter int unsigned DLY_512   = 512,
    parameter int unsigned DLY_1S    = 1000,
    parameter int unsigned DLY_2S    = 2000,
    parameter int unsigned DLY_4S    = 4000,
    parameter int unsigned DLY_8S    = 8000,
    parameter int unsigned DLY_QUICK = 8,
    parameter int unsigned TRST_MS   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NCELL-1:0] cell_over,
    input  logic [NCELL-1:0] cell_hold,
    input  logic             ctl_in,
    input  logic             quick_in,
    input  logic [2:0]       dly_sel,
    output logic             chg_block_o
);
    localparam int unsigned DMAX = (DLY_8S > DLY_QUICK) ? DLY_8S : DLY_QUICK;
    localparam int unsigned DW   = $clog2(DMAX + 1);
    localparam int unsigned GW   = $clog2(TRST_MS + 1);

    ovc_state_e    st, nx;
    logic [DW-1:0] dcnt, tgt;
    logic [GW-1:0] gcnt;
    logic [2:0]    sel_q;
    logic          d_clr, d_inc, g_clr, g_inc;
    logic          any_over, any_hold;
    logic          full_next, gap_expire;

    assign any_over   = |cell_over;
    assign any_hold   = |cell_hold;
    assign full_next  = ({1'b0, dcnt} + (DW+1)'(1)) >= {1'b0, tgt};
    assign gap_expire = ({1'b0, gcnt} + (GW+1)'(1)) >= (GW+1)'(TRST_MS);

    ovc_delay_sel #(
        .DLY_512(DLY_512), .DLY_1S(DLY_1S), .DLY_2S(DLY_2S),
        .DLY_4S(DLY_4S), .DLY_8S(DLY_8S), .DLY_QUICK(DLY_QUICK), .DW(DW)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .capture(st == ST_IDLE),
        .sel(dly_sel), .quick(quick_in), .sel_q(sel_q), .tgt(tgt)
    );

    ovc_count #(.W(DW)) u_dcnt (
        .clk(clk), .rst_n(rst_n), .clr(d_clr), .inc(d_inc), .q(dcnt)
    );

    ovc_count #(.W(GW)) u_gcnt (
        .clk(clk), .rst_n(rst_n), .clr(g_clr), .inc(g_inc), .q(gcnt)
    );

    // next state and counter controls
    always_comb begin
        nx    = st;
        d_clr = 1'b0;
        d_inc = 1'b0;
        g_clr = 1'b0;
        g_inc = 1'b0;
        if (tick) begin
            unique case (st)
                ST_TRIP: begin
                    if (!any_hold) begin
                        nx = ST_IDLE;
                    end
                end
                ST_IDLE, ST_COUNT, ST_GAP: begin
                    if (any_over) begin
                        g_clr = 1'b1;
                        if (full_next) begin
                            nx    = ST_TRIP;
                            d_clr = 1'b1;
                        end else begin
                            nx    = ST_COUNT;
                            d_inc = 1'b1;
                        end
                    end else if (st != ST_IDLE) begin
                        if (gap_expire) begin
                            nx    = ST_IDLE;
                            d_clr = 1'b1;
                            g_clr = 1'b1;
                        end else begin
                            nx    = ST_GAP;
                            g_inc = 1'b1;
                        end
                    end
                end
                default: nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else if (tick) begin
            st <= nx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_block_o <= 1'b0;
        end else if (tick) begin
            chg_block_o <= (nx == ST_TRIP) || ctl_in;
        end
    end
endmodule

// File: rtl/ovc_delay_guard_chk.sv
module ovc_delay_guard_chk
    import ovc_pkg::*;
#(
    parameter int unsigned NCELL = 5,
    parameter int unsigned DW    = 13,
    parameter int unsigned GW    = 4,
    parameter int unsigned TRST  = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ctl_in,
    input logic [NCELL-1:0] cell_hold,
    input logic             chg_block_o,
    input ovc_state_e       st,
    input logic [DW-1:0]    dcnt,
    input logic [DW-1:0]    tgt,
    input logic [GW-1:0]    gcnt,
    input logic [2:0]       sel_q
);
    a_r1_idle_counters_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (dcnt == '0 && gcnt == '0));

    a_r2_trip_at_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_TRIP) |-> (({1'b0, $past(dcnt)} + (DW+1)'(1)) >= {1'b0, $past(tgt)}));

    a_r4_gap_below_filter: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, gcnt} < (GW+1)'(TRST)));

    a_r5_trip_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRIP && ((|cell_hold) || !tick)) |=> chg_block_o);

    a_r6_ctl_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctl_in) |=> chg_block_o);

    a_r8_select_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(sel_q));

    a_r9_quiet_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(chg_block_o) && $stable(st) && $stable(dcnt)));
endmodule

bind ovc_delay_guard ovc_delay_guard_chk #(
    .NCELL(NCELL), .DW(DW), .GW(GW), .TRST(TRST_MS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_in(ctl_in),
    .cell_hold(cell_hold), .chg_block_o(chg_block_o), .st(st),
    .dcnt(dcnt), .tgt(tgt), .gcnt(gcnt), .sel_q(sel_q)
);

// File: tb/ovc_delay_guard_tb.sv
module ovc_delay_guard_tb;
    localparam int NC = 5;
    localparam int D0 = 12, D1 = 16, D2 = 20, D3 = 24, D4 = 28;
    localparam int DQ = 6;
    localparam int TR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [NC-1:0] cell_over = '0;
    logic [NC-1:0] cell_hold = '0;
    logic          ctl_in = 1'b0;
    logic          quick_in = 1'b0;
    logic [2:0]    dly_sel = 3'd0;
    logic          chg_block_o;

    int nchk = 0;
    int nerr = 0;

    // reference model state
    bit m_trip = 0, m_act = 0;
    int m_acc = 0, m_gap = 0;
    int m_sel = 0;
    bit m_exp = 0;

    always #4 clk = ~clk;

    ovc_delay_guard #(
        .NCELL(NC), .DLY_512(D0), .DLY_1S(D1), .DLY_2S(D2), .DLY_4S(D3),
        .DLY_8S(D4), .DLY_QUICK(DQ), .TRST_MS(TR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cell_over(cell_over),
        .cell_hold(cell_hold), .ctl_in(ctl_in), .quick_in(quick_in),
        .dly_sel(dly_sel), .chg_block_o(chg_block_o)
    );

    function automatic int delay_of(input int s);
        case (s)
            0: return D0;
            1: return D1;
            2: return D2;
            3: return D3;
            default: return D4;
        endcase
    endfunction

    task automatic model_tick();
        int t;
        if (!m_trip && !m_act) m_sel = int'(dly_sel);
        t = quick_in ? DQ : delay_of(m_sel);
        if (m_trip) begin
            if (cell_hold == '0) m_trip = 0;
        end else if (cell_over != '0) begin
            m_gap = 0;
            if (m_acc + 1 >= t) begin
                m_trip = 1; m_act = 0; m_acc = 0;
            end else begin
                m_act = 1; m_acc++;
            end
        end else if (m_act) begin
            if (m_gap + 1 >= TR) begin
                m_act = 0; m_acc = 0; m_gap = 0;
            end else begin
                m_gap++;
            end
        end
        m_exp = m_trip | ctl_in;
    endtask

    task automatic check(input string tag, input bit act, input bit exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [NC-1:0] ov, input logic [NC-1:0] hv,
                        input logic c, input logic q, input logic [2:0] s,
                        input string tag);
        @(negedge clk);
        cell_over = ov; cell_hold = hv | ov; ctl_in = c; quick_in = q; dly_sel = s;
        tick = 1'b0;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
        check(tag, chg_block_o, m_exp);
        @(negedge clk);
        check({"R9 hold between ticks / ", tag}, chg_block_o, m_exp);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, 1'b0, 1'b0, 3'd0, "R5 release settle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C5E_ED01));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset output low", chg_block_o, 1'b0);

        // R2: every select code, trips exactly at the target tick
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < delay_of(s) + 1; i++)
                step(5'b00001 << (s % NC), '0, 1'b0, 1'b0, 3'(s), "R2 delay select");
            settle(2);
        end

        // R3: short dip keeps the count
        for (int i = 0; i < 5; i++) step(5'b00010, '0, 0, 0, 3'd0, "R3 count before dip");
        for (int i = 0; i < TR - 1; i++) step('0, '0, 0, 0, 3'd0, "R3 short dip");
        for (int i = 0; i < D0 - 5; i++) step(5'b01000, '0, 0, 0, 3'd0, "R3 resume to trip");
        check("R3 tripped on accumulated count", chg_block_o, 1'b1);
        settle(2);

        // R4: long dip clears the count
        for (int i = 0; i < 5; i++) step(5'b00010, '0, 0, 0, 3'd0, "R4 count before dip");
        for (int i = 0; i < TR; i++) step('0, '0, 0, 0, 3'd0, "R4 long dip");
        for (int i = 0; i < D0 - 1; i++) step(5'b00010, '0, 0, 0, 3'd0, "R4 restart from one");
        check("R4 not yet tripped after restart", chg_block_o, 1'b0);
        step(5'b00010, '0, 0, 0, 3'd0, "R4 trip after full restart");
        check("R4 trip after full restart", chg_block_o, 1'b1);

        // R5: hysteresis hold then release
        for (int i = 0; i < 4; i++) step('0, 5'b00100, 0, 0, 3'd0, "R5 held by release level");
        step('0, '0, 0, 0, 3'd0, "R5 release");
        check("R5 released low", chg_block_o, 1'b0);

        // R6: upstream force in normal status, and colliding with release
        step('0, '0, 1, 0, 3'd0, "R6 force in normal");
        step('0, '0, 0, 0, 3'd0, "R6 force removed");
        for (int i = 0; i < D0; i++) step(5'b10000, '0, 0, 0, 3'd0, "R6 reach trip");
        step('0, 5'b00001, 1, 0, 3'd0, "R6 force in trip");
        step('0, '0, 1, 0, 3'd0, "R6 force on release tick");
        check("R6 force on release tick", chg_block_o, 1'b1);
        step('0, '0, 0, 0, 3'd0, "R6 after force and release");

        // R7: quick mode overrides the select code
        for (int i = 0; i < DQ; i++) step(5'b00001, '0, 0, 1, 3'd4, "R7 quick delay");
        check("R7 quick trip", chg_block_o, 1'b1);
        step('0, '0, 0, 1, 3'd0, "R7 release");

        // R8: select change during a count is ignored
        for (int i = 0; i < 3; i++) step(5'b00001, '0, 0, 0, 3'd0, "R8 start with code 0");
        for (int i = 0; i < D0 - 3; i++) step(5'b00001, '0, 0, 0, 3'd4, "R8 code changed mid-count");
        check("R8 trip on captured code", chg_block_o, 1'b1);
        settle(2);

        // random mix
        begin
            bit hi = 0;
            for (int n = 0; n < 3000; n++) begin
                logic [NC-1:0] ov, hv;
                if ($urandom % 9 == 0) hi = ~hi;
                ov = hi ? NC'($urandom) : ((($urandom % 6) == 0) ? NC'($urandom) : '0);
                hv = NC'($urandom) & NC'($urandom);
                step(ov, hv, ($urandom % 23) == 0, ($urandom % 40) == 0,
                     3'($urandom), "R2 random mix");
            end
        end

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule